// File: doc/BRIEF.md
# Periodic Interval Timer

The block counts down a programmable interval on a slow-clock enable and raises an event each time that interval has fully elapsed. A 16-bit down-counter advances once per enable pulse. When it is at zero on an enabled cycle it reloads from the programmed period, so events repeat with no software action. A programmed period of zero selects the longest interval, 65536 enabled cycles.

Each event sets a sticky status flag, and reading the status location clears it. An interrupt mask decides whether the flag drives the level-sensitive interrupt output. The mask has separate write-one-to-set and write-one-to-clear locations and a read-only location that returns it. Software reaches the block through a simple single-cycle register port. Writes are accepted in the cycle `wr_en_i` is high. Read data is combinational on `rd_addr_i`, and the status clear takes effect at the clock edge that ends a cycle with `rd_en_i` high.

Top module: `pit_timer`

## Requirements
- R1: Address 0 holds the period in bits 15..0 and reads it back with the upper bits zero. A write to it restarts the count, so the first event follows after exactly the programmed number of enabled cycles.
- R2: The counter changes only in cycles with `tick_i` high. Without `tick_i`, no event occurs, however many clock cycles pass.
- R3: Events repeat every P enabled cycles for a programmed period P from 1 to 65535. A programmed period of 0 gives 65536 enabled cycles.
- R4: Address 1 returns the status flag in bit 0. An event sets it. A read of address 1 with `rd_en_i` high returns the flag and clears it at the end of that cycle.
- R5: If an event falls in the same cycle as a status read, the flag is still set after that cycle.
- R6: Writing 1 in bit 0 at address 2 sets the mask bit. Writing 1 in bit 0 at address 3 clears it. Writing 0 in bit 0 at either address leaves the mask unchanged.
- R7: Address 4 returns the mask bit in bit 0. Unmapped addresses 5 to 7 read as zero.
- R8: `irq_o` is high exactly while both the status flag and the mask bit are set.
- R9: After reset, the period is 0, the counter is at its full value, the flag is 0 and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow-clock enable, one pulse per counted cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe (side effect: status clear) |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Level interrupt, flag AND mask |

## Verification
A counter event and a status read can fall in the same cycle. That is the case in which a lost interrupt would hide. The bench programs a period of 1 with the enable held high, so that every enabled cycle is an event. It then issues a status read in such a cycle. It checks that the read returns the old value of the flag and that the flag is set again at the next cycle. A read in a cycle without an enable is used as the contrast, and it must leave the flag clear.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_MSET   = 3'd2;
  localparam logic [ADDR_W-1:0] A_MCLR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd4;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  period_o,
  output logic              mask_o,
  output logic              reload_o
);
  logic set_hit, clr_hit;

  assign reload_o = wr_en_i && (wr_addr_i == A_PERIOD);
  assign set_hit  = wr_en_i && (wr_addr_i == A_MSET) && wr_data_i[0];
  assign clr_hit  = wr_en_i && (wr_addr_i == A_MCLR) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= '0;
      mask_o   <= 1'b0;
    end else begin
      if (reload_o) period_o <= wr_data_i[CNT_W-1:0];
      if (set_hit)      mask_o <= 1'b1;
      else if (clr_hit) mask_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt_o
);
  // period 0 wraps to all-ones: full 2**CNT_W interval
  assign zero_evt_o = tick_i && (cnt_o == '0) && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_o <= '1;
    else if (reload_i)   cnt_o <= load_val_i - CNT_W'(1);
    else if (zero_evt_o) cnt_o <= period_i - CNT_W'(1);
    else if (tick_i)     cnt_o <= cnt_o - CNT_W'(1);
  end
endmodule

// File: rtl/pit_status.sv
module pit_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over clear so a coincident event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (evt_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] period_q, cnt_q;
  logic             mask_q, flag_q, reload, zero_evt, stat_clr;

  assign stat_clr = rd_en_i && (rd_addr_i == A_STATUS);

  pit_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .period_o(period_q), .mask_o(mask_q), .reload_o(reload)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .reload_i(reload),
    .load_val_i(wr_data_i[CNT_W-1:0]), .period_i(period_q),
    .cnt_o(cnt_q), .zero_evt_o(zero_evt)
  );

  pit_status u_stat (
    .clk_i, .rst_ni, .evt_i(zero_evt), .clr_i(stat_clr), .flag_o(flag_q)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_PERIOD: rd_data_o = DATA_W'(period_q);
      A_STATUS: rd_data_o = DATA_W'(flag_q);
      A_MASK:   rd_data_o = DATA_W'(mask_q);
      default:  rd_data_o = '0;
    endcase
  end

  assign irq_o = flag_q & mask_q;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [2:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [2:0]        rd_addr_i,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  period_q,
  input logic              flag_q,
  input logic              mask_q,
  input logic              irq_o
);
  logic prd_wr, set_wr, clr_wr, st_rd, at_zero;
  assign prd_wr  = wr_en_i && (wr_addr_i == 3'd0);
  assign set_wr  = wr_en_i && (wr_addr_i == 3'd2) && wr_data_i[0];
  assign clr_wr  = wr_en_i && (wr_addr_i == 3'd3) && wr_data_i[0];
  assign st_rd   = rd_en_i && (rd_addr_i == 3'd1);
  assign at_zero = tick_i && (cnt_q == '0) && !prd_wr;

  // R1: a period write restarts the count from the new value
  a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_wr |=> cnt_q == period_q - CNT_W'(1));

  // R2: no tick, no movement
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !prd_wr) |=> $stable(cnt_q));

  // R3: step down once per tick, reload at zero
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !prd_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_zero |=> cnt_q == period_q - CNT_W'(1));

  // R4: event sets the flag, a plain read clears it
  a_r4_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_zero |=> flag_q);
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd && !at_zero) |=> !flag_q);

  // R5: coincident event and read keep the flag
  a_r5_no_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd && at_zero) |=> flag_q);

  // R6: split set/clear mask control
  a_r6_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> mask_q);
  a_r6_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> !mask_q);
  a_r6_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_wr && !clr_wr) |=> $stable(mask_q));

  // R8: interrupt rises only when both enable and flag are set
  a_r8_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (flag_q && mask_q));
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
  .rd_addr_i(rd_addr_i), .cnt_q(cnt_q), .period_q(period_q),
  .flag_q(flag_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/pit_timer_bench.sv
`timescale 1ns/1ps
module pit_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pit_timer u_pit_timer (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t);
    tick_i = t;
    @(posedge clk_i); #1;
    tick_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  // read with strobe; data sampled before the edge
  task automatic rd(input logic [2:0] a, input logic t, output logic [31:0] d);
    rd_en_i = 1'b1; rd_addr_i = a; tick_i = t;
    #1 d = rd_data_o;
    @(posedge clk_i); #1;
    rd_en_i = 1'b0; tick_i = 1'b0;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R9: reset state
    chk("R9 irq", {31'd0, irq_o}, 32'd0);
    rd(3'd0, 1'b0, v); chk("R9 period", v, 32'd0);
    rd(3'd1, 1'b0, v); chk("R9 flag", v, 32'd0);
    rd(3'd4, 1'b0, v); chk("R9 mask", v, 32'd0);

    // R7: unmapped addresses
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), 1'b0, v); chk("R7 unmapped", v, 32'd0);
    end

    // R6: zero writes do nothing, ones set/clear
    wr(3'd2, 32'hFFFF_FFFE); rd(3'd4, 1'b0, v); chk("R6 set zero bit", v, 32'd0);
    wr(3'd2, 32'd1);         rd(3'd4, 1'b0, v); chk("R6 set", v, 32'd1);
    chk("R7 mask read", v, 32'd1);
    wr(3'd3, 32'hFFFF_FFFE); rd(3'd4, 1'b0, v); chk("R6 clr zero bit", v, 32'd1);
    wr(3'd3, 32'd1);         rd(3'd4, 1'b0, v); chk("R6 clr", v, 32'd0);
    wr(3'd2, 32'd1);

    // R1/R3/R8: sweep periods 1..8, two intervals each, tick every cycle
    for (int p = 1; p <= 8; p++) begin
      wr(3'd0, 32'hABCD_0000 | 32'(p));
      rd(3'd0, 1'b0, v); chk("R1 readback", v, 32'(p));
      rd(3'd1, 1'b0, v);
      for (int r = 0; r < 2; r++) begin
        for (int n = 1; n <= p; n++) begin
          cyc(1'b1);
          chk("R3 interval irq", {31'd0, irq_o}, {31'd0, n == p});
        end
        rd(3'd1, 1'b0, v); chk("R4 status read", v, 32'd1);
        chk("R4 cleared", {31'd0, irq_o}, 32'd0);
      end
    end

    // R2: sparse ticks, period 3; idle cycles add nothing
    wr(3'd0, 32'd3); rd(3'd1, 1'b0, v);
    for (int n = 1; n <= 3; n++) begin
      repeat (5) cyc(1'b0);
      chk("R2 idle no event", {31'd0, irq_o}, 32'd0);
      cyc(1'b1);
      chk("R2 sparse ticks", {31'd0, irq_o}, {31'd0, n == 3});
    end
    rd(3'd1, 1'b0, v);
    repeat (40) cyc(1'b0);
    rd(3'd1, 1'b0, v); chk("R2 no tick no flag", v, 32'd0);

    // R8: mask gates the level
    wr(3'd0, 32'd1); rd(3'd1, 1'b0, v);
    cyc(1'b1);
    chk("R8 irq on", {31'd0, irq_o}, 32'd1);
    wr(3'd3, 32'd1);
    chk("R8 masked", {31'd0, irq_o}, 32'd0);
    wr(3'd2, 32'd0);
    chk("R8 zero set keeps off", {31'd0, irq_o}, 32'd0);
    wr(3'd2, 32'd1);
    chk("R8 unmasked again", {31'd0, irq_o}, 32'd1);

    // R5: read coincides with event (period 1, tick on)
    rd(3'd1, 1'b0, v); chk("R4 clear before collision", {31'd0, irq_o}, 32'd0);
    rd(3'd1, 1'b1, v);
    chk("R5 read sees old", v, 32'd0);
    chk("R5 flag kept", {31'd0, irq_o}, 32'd1);
    cyc(1'b1);
    rd(3'd1, 1'b1, v);
    chk("R5 read sees set", v, 32'd1);
    chk("R5 flag kept again", {31'd0, irq_o}, 32'd1);
    rd(3'd1, 1'b0, v);
    chk("R4 plain read clears", {31'd0, irq_o}, 32'd0);

    // R3: period 0 is 65536 ticks
    wr(3'd0, 32'd0); rd(3'd1, 1'b0, v);
    tick_i = 1'b1;
    repeat (65535) @(posedge clk_i);
    #1 chk("R3 full period not yet", {31'd0, irq_o}, 32'd0);
    @(posedge clk_i); #1;
    tick_i = 1'b0;
    chk("R3 full period event", {31'd0, irq_o}, 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule